// File: doc/BRIEF.md
# Radiation-Tolerant I2C Configuration Register Slave

This block is an I2C slave that answers at the fixed 7-bit address 0x54 and holds the configuration of a front-end clock and test-pulse distributor. It keeps seven 8-bit registers. Registers 0 to 4 hold clock phase-shift settings, register 5 is a command register and register 6 is a read-only status byte. The shift and command registers drive the surrounding logic directly. SCL and SDA are sampled with the system clock. The slave drives SDA only through an open-drain enable: when `sda_oe_o` is 1 the pad pulls the line low.

A write transfer carries a register pointer and then data bytes, which land in consecutive registers. A read transfer returns bytes starting at the pointer that an earlier write left, and continues while the master acknowledges. Every stored word is kept in three copies and read through a 2-of-3 majority vote. This covers the six writable registers, the pointer and the upset counter. A copy that disagrees with the vote is rewritten on the next clock, and each such repair bumps a saturating 6-bit counter that appears in the status byte. A small injection port flips a single bit of one copy, so the correction path can be exercised.

Top module: `i2c_tmr_regfile`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits equal 0x54. Any other address is left unacknowledged, and the rest of that transfer is ignored.
- R2: In a write transfer, the first byte after the address loads the pointer. Each later byte is written to the register at the pointer, and the pointer then advances. `shift_o[8*k+7:8*k]` shows register k for k = 0..4.
- R3: The slave drives acknowledge (SDA low) for every pointer and data byte it receives. It changes `sda_oe_o` only while SCL is low.
- R4: A read transfer (address LSB = 1) returns the register at the pointer, most significant bit first. It advances to the next register after each master acknowledge and stops at the first master non-acknowledge.
- R5: A read transfer never loads the pointer. Two single-byte reads in a row return the same register.
- R6: Writing to register 6 (status) changes no register, though the byte is still acknowledged and the pointer still advances.
- R7: Status bit 0 is the 80 MHz lock input, bit 1 is the 40 MHz lock input, and bits 7:2 are the upset counter.
- R8: A single flipped bit in one copy of any stored word leaves the voted outputs unchanged. The copy is repaired, and the counter increases by exactly one.
- R9: The upset counter saturates at 63.
- R10: While command bit 3 is 1, the upset counter is held at 0. Command bit 7 drives `chip_rst_o`, and `cmd_o` shows register 5.
- R11: The pointer advances from 6 to 0. A pointer above 6 reads as 0x00, writes to it are discarded, and it then advances to 0.
- R12: After reset all registers, the pointer and the counter are 0, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| lock80_i | input | 1 | 80 MHz PLL lock, status bit 0 |
| lock40_i | input | 1 | 40 MHz PLL lock, status bit 1 |
| upset_en_i | input | 1 | Single-cycle strobe that flips one stored bit |
| upset_tgt_i | input | 3 | Word to disturb: 0-5 registers, 6 counter, 7 pointer |
| upset_copy_i | input | 2 | Copy to disturb (0..2; 3 does nothing) |
| upset_bit_i | input | 3 | Bit position to flip |
| shift_o | output | 40 | Registers 0..4, register k in bits 8k+7:8k |
| cmd_o | output | 8 | Command register (register 5) |
| chip_rst_o | output | 1 | Front-end chip reset, command bit 7 |

## Verification
SCL and SDA pass through two synchronizer flops, and the edge detector adds one more. So the acknowledge or data bit appears on `sda_oe_o` three clocks after SCL falls. The bench samples SDA in the middle of SCL high, at least eight clocks after that, and it waits the same margin before raising SCL. A data byte reaches `shift_o` or `cmd_o` about five clocks after the acknowledge-bit SCL fall, so register outputs are checked only after the stop condition. The injection strobe flips a copy on the next edge, and the repair and counter step follow on the edge after that. Port checks therefore wait three clocks after a strobe, and the counter is always read back through an I2C read rather than sampled.

// File: rtl/i2c_tmr_pkg.sv
package i2c_tmr_pkg;

    localparam int DATA_W     = 8;
    localparam int NUM_CFG    = 6;
    localparam int NUM_SHIFT  = 5;
    localparam int CMD_IDX    = 5;
    localparam int STATUS_IDX = 6;
    localparam int CNT_W      = 6;
    localparam int TGT_W      = 3;
    localparam int BIDX_W     = 3;
    localparam int TGT_CNT    = 6;
    localparam int TGT_PTR    = 7;
    localparam int CMD_CLR_BIT   = 3;
    localparam int CMD_FERST_BIT = 7;
    localparam logic [6:0] DEV_ADDR = 7'h54;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_ADDR,
        LS_ADDR_ACK,
        LS_RX,
        LS_RX_ACK,
        LS_TX,
        LS_TX_ACK
    } link_state_e;

    // Pointer step: wraps after the status register, out-of-range goes to 0
    function automatic logic [DATA_W-1:0] ptr_next(input logic [DATA_W-1:0] p);
        return (p >= DATA_W'(STATUS_IDX)) ? '0 : p + 1'b1;
    endfunction

endpackage

// File: rtl/i2c_tmr_word.sv
module i2c_tmr_word #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         inj_en,
    input  logic [1:0]   inj_copy,
    input  logic [2:0]   inj_bit,
    output logic [W-1:0] q,
    output logic         corrected
);

    logic [W-1:0] copy_q [3];
    logic [W-1:0] voted;
    logic [W-1:0] flip_mask;

    always_comb begin
        voted = (copy_q[0] & copy_q[1]) | (copy_q[0] & copy_q[2]) | (copy_q[1] & copy_q[2]);
    end

    always_comb begin
        flip_mask = '0;
        if (int'(inj_bit) < W) flip_mask[inj_bit] = 1'b1;
    end

    assign corrected = (copy_q[0] != voted) || (copy_q[1] != voted) || (copy_q[2] != voted);
    assign q = voted;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 3; c++) copy_q[c] <= '0;
        end else if (we) begin
            for (int c = 0; c < 3; c++) copy_q[c] <= wdata;
        end else begin
            for (int c = 0; c < 3; c++) begin
                if (inj_en && inj_copy == 2'(c)) copy_q[c] <= copy_q[c] ^ flip_mask;
                else if (corrected)              copy_q[c] <= voted;
            end
        end
    end

endmodule

// File: rtl/i2c_link.sv
module i2c_link
    import i2c_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              ptr_load,
    output logic              wr_en,
    output logic              ptr_step,
    output logic [DATA_W-1:0] rx_byte
);

    link_state_e       state;
    logic              scl_q, sda_q;
    logic [2:0]        bitcnt;
    logic [DATA_W-1:0] shreg;
    logic              byte_full, ptr_phase, rw, acked;
    logic              scl_rise, scl_fall, start_c, stop_c;

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
    assign rx_byte  = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= LS_IDLE;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            bitcnt    <= '0;
            shreg     <= '0;
            byte_full <= 1'b0;
            ptr_phase <= 1'b0;
            rw        <= 1'b0;
            acked     <= 1'b0;
            sda_oe    <= 1'b0;
            ptr_load  <= 1'b0;
            wr_en     <= 1'b0;
            ptr_step  <= 1'b0;
        end else begin
            scl_q    <= scl_s;
            sda_q    <= sda_s;
            ptr_load <= 1'b0;
            wr_en    <= 1'b0;
            ptr_step <= 1'b0;
            if (start_c) begin
                state     <= LS_ADDR;
                bitcnt    <= '0;
                byte_full <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (stop_c) begin
                state  <= LS_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    LS_ADDR, LS_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[DATA_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == 3'd7) byte_full <= 1'b1;
                        end else if (scl_fall && byte_full) begin
                            byte_full <= 1'b0;
                            if (state == LS_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                    state  <= LS_ADDR_ACK;
                                end else begin
                                    state <= LS_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= LS_RX_ACK;
                                if (ptr_phase) ptr_load <= 1'b1;
                                else           wr_en    <= 1'b1;
                            end
                        end
                    end
                    LS_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                state  <= LS_TX;
                                shreg  <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                            end else begin
                                state     <= LS_RX;
                                ptr_phase <= 1'b1;
                                sda_oe    <= 1'b0;
                            end
                        end
                    end
                    LS_RX_ACK: begin
                        if (scl_fall) begin
                            sda_oe    <= 1'b0;
                            ptr_phase <= 1'b0;
                            bitcnt    <= '0;
                            state     <= LS_RX;
                        end
                    end
                    LS_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                acked  <= 1'b0;
                                state  <= LS_TX_ACK;
                            end else begin
                                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                                sda_oe <= ~shreg[6];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    LS_TX_ACK: begin
                        if (scl_rise) begin
                            if (!sda_s) begin
                                acked    <= 1'b1;
                                ptr_step <= 1'b1;
                            end else begin
                                state <= LS_IDLE;
                            end
                        end else if (scl_fall && acked) begin
                            acked  <= 1'b0;
                            bitcnt <= '0;
                            state  <= LS_TX;
                            shreg  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_tmr_regfile.sv
module i2c_tmr_regfile
    import i2c_tmr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_oe_o,
    input  logic                        lock80_i,
    input  logic                        lock40_i,
    input  logic                        upset_en_i,
    input  logic [TGT_W-1:0]            upset_tgt_i,
    input  logic [1:0]                  upset_copy_i,
    input  logic [BIDX_W-1:0]           upset_bit_i,
    output logic [NUM_SHIFT*DATA_W-1:0] shift_o,
    output logic [DATA_W-1:0]           cmd_o,
    output logic                        chip_rst_o
);

    localparam int NUM_WORDS = NUM_CFG + 2;

    logic scl_m, scl_s, sda_m, sda_s;
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_m <= 1'b1; scl_s <= 1'b1;
            sda_m <= 1'b1; sda_s <= 1'b1;
        end else begin
            scl_m <= scl_i; scl_s <= scl_m;
            sda_m <= sda_i; sda_s <= sda_m;
        end
    end

    logic              ptr_load, wr_en, ptr_step;
    logic [DATA_W-1:0] rx_byte, rd_byte;

    i2c_link link_i (
        .clk      (clk),
        .rst      (rst),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .rd_byte  (rd_byte),
        .sda_oe   (sda_oe_o),
        .ptr_load (ptr_load),
        .wr_en    (wr_en),
        .ptr_step (ptr_step),
        .rx_byte  (rx_byte)
    );

    logic [NUM_WORDS-1:0] corr_vec;

    // Pointer, triplicated
    logic [DATA_W-1:0] ptr_q, ptr_wd;
    logic              ptr_we;
    assign ptr_we = ptr_load | ptr_step | wr_en;
    assign ptr_wd = ptr_load ? rx_byte : ptr_next(ptr_q);

    i2c_tmr_word #(.W(DATA_W)) ptr_word_i (
        .clk       (clk),
        .rst       (rst),
        .we        (ptr_we),
        .wdata     (ptr_wd),
        .inj_en    (upset_en_i && upset_tgt_i == TGT_W'(TGT_PTR)),
        .inj_copy  (upset_copy_i),
        .inj_bit   (upset_bit_i),
        .q         (ptr_q),
        .corrected (corr_vec[NUM_CFG+1])
    );

    // Writable registers, triplicated
    logic [DATA_W-1:0] cfg_q [NUM_CFG];
    for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
        i2c_tmr_word #(.W(DATA_W)) cfg_word_i (
            .clk       (clk),
            .rst       (rst),
            .we        (wr_en && ptr_q == DATA_W'(i)),
            .wdata     (rx_byte),
            .inj_en    (upset_en_i && upset_tgt_i == TGT_W'(i)),
            .inj_copy  (upset_copy_i),
            .inj_bit   (upset_bit_i),
            .q         (cfg_q[i]),
            .corrected (corr_vec[i])
        );
    end

    for (genvar j = 0; j < NUM_SHIFT; j++) begin : g_shift
        assign shift_o[j*DATA_W +: DATA_W] = cfg_q[j];
    end
    assign cmd_o      = cfg_q[CMD_IDX];
    assign chip_rst_o = cmd_o[CMD_FERST_BIT];

    // Upset counter, triplicated
    logic [CNT_W-1:0] cnt_q, cnt_wd;
    logic             cnt_we;
    always_comb begin
        cnt_we = 1'b0;
        cnt_wd = cnt_q;
        if (cmd_o[CMD_CLR_BIT]) begin
            cnt_we = (cnt_q != '0);
            cnt_wd = '0;
        end else if ((|corr_vec) && (cnt_q != '1)) begin
            cnt_we = 1'b1;
            cnt_wd = cnt_q + 1'b1;
        end
    end

    i2c_tmr_word #(.W(CNT_W)) cnt_word_i (
        .clk       (clk),
        .rst       (rst),
        .we        (cnt_we),
        .wdata     (cnt_wd),
        .inj_en    (upset_en_i && upset_tgt_i == TGT_W'(TGT_CNT)),
        .inj_copy  (upset_copy_i),
        .inj_bit   (upset_bit_i),
        .q         (cnt_q),
        .corrected (corr_vec[NUM_CFG])
    );

    // Read mux
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (ptr_q == DATA_W'(i)) rd_byte = cfg_q[i];
        end
        if (ptr_q == DATA_W'(STATUS_IDX)) rd_byte = {cnt_q, lock40_i, lock80_i};
    end

endmodule

// File: rtl/i2c_tmr_regfile_chk.sv
module i2c_tmr_regfile_chk
    import i2c_tmr_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        sda_oe,
    input logic                        scl_s,
    input logic [DATA_W-1:0]           cmd,
    input logic [CNT_W-1:0]            cnt,
    input logic                        wr_en,
    input logic [DATA_W-1:0]           ptr,
    input logic [NUM_SHIFT*DATA_W-1:0] shift
);

    p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);

    p_status_ro_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ptr == DATA_W'(STATUS_IDX)) |=> ($stable(shift) && $stable(cmd)));

    p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
        !cmd[CMD_CLR_BIT] |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    p_cnt_sat_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1 && !cmd[CMD_CLR_BIT]) |=> cnt == '1);

    p_cnt_clr_r10: assert property (@(posedge clk) disable iff (rst)
        cmd[CMD_CLR_BIT] |=> cnt == '0);

    p_oob_write_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ptr > DATA_W'(STATUS_IDX)) |=> ($stable(shift) && $stable(cmd)));

endmodule

bind i2c_tmr_regfile i2c_tmr_regfile_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .sda_oe (sda_oe_o),
    .scl_s  (scl_s),
    .cmd    (cmd_o),
    .cnt    (cnt_q),
    .wr_en  (wr_en),
    .ptr    (ptr_q),
    .shift  (shift_o)
);

// File: tb/i2c_tmr_regfile_tb_top.sv
module i2c_tmr_regfile_tb_top;

    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        lock80 = 1'b1, lock40 = 1'b0;
    logic        upset_en = 1'b0;
    logic [2:0]  upset_tgt = '0;
    logic [1:0]  upset_copy = '0;
    logic [2:0]  upset_bit = '0;
    logic        sda_oe;
    logic [39:0] shift;
    logic [7:0]  cmd;
    logic        chip_rst;
    logic        sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_tmr_regfile dut_i (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .lock80_i     (lock80),
        .lock40_i     (lock40),
        .upset_en_i   (upset_en),
        .upset_tgt_i  (upset_tgt),
        .upset_copy_i (upset_copy),
        .upset_bit_i  (upset_bit),
        .shift_o      (shift),
        .cmd_o        (cmd),
        .chip_rst_o   (chip_rst)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] act_q [$];

    // Scoreboard monitor
    always @(negedge clk) begin
        if (act_q.size() > 0) begin
            logic [7:0] a, e;
            string t;
            a = act_q.pop_front();
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: unexpected item actual=%h expected=none", a);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    task automatic chk(input string t, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", t, act, expv);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input logic [7:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic m_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic m_bit(input logic b, output logic r);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(Q);
        r = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    // Sends a byte; the ack bit is pushed to the scoreboard (0 = ack)
    task automatic m_send(input logic [7:0] v, input logic exp_ack_bit, input string t);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(v[i], r);
        push_exp({7'd0, exp_ack_bit}, t);
        m_bit(1'b1, r);
        act_q.push_back({7'd0, r});
    endtask

    task automatic m_recv(input logic [7:0] expv, input logic last, input string t);
        logic r;
        logic [7:0] v;
        v = '0;
        push_exp(expv, t);
        for (int i = 0; i < 8; i++) begin
            m_bit(1'b1, r);
            v = {v[6:0], r};
        end
        act_q.push_back(v);
        m_bit(last, r);
    endtask

    task automatic wr_begin(input logic [7:0] p);
        m_start();
        m_send(8'hA8, 1'b0, "R1 address ack (write)");
        m_send(p, 1'b0, "R3 pointer byte ack");
    endtask

    task automatic rd_begin();
        m_start();
        m_send(8'hA9, 1'b0, "R1 address ack (read)");
    endtask

    task automatic set_ptr(input logic [7:0] p);
        wr_begin(p);
        m_stop();
    endtask

    task automatic inject(input logic [2:0] tg, input logic [1:0] cp, input logic [2:0] bt);
        upset_tgt = tg; upset_copy = cp; upset_bit = bt; upset_en = 1'b1;
        wq(1);
        upset_en = 1'b0;
        wq(3);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wq(5);
        rst = 1'b0;
        wq(2);
        // R12 reset state
        chk("R12 reset shift_o", 64'(shift), 64'h0);
        chk("R12 reset cmd_o", 64'(cmd), 64'h0);
        chk("R12 reset sda released", 64'(sda_oe), 64'h0);

        // R2 / R3 multi-byte write
        wr_begin(8'h00);
        m_send(8'h11, 1'b0, "R3 data ack");
        m_send(8'h22, 1'b0, "R3 data ack");
        m_send(8'h33, 1'b0, "R3 data ack");
        m_send(8'h44, 1'b0, "R3 data ack");
        m_send(8'h55, 1'b0, "R3 data ack");
        m_stop();
        chk("R2 consecutive write", 64'(shift), 64'h55_44_33_22_11);

        // R1 wrong address: no ack, following byte ignored
        m_start();
        m_send(8'hAA, 1'b1, "R1 foreign address nack");
        m_send(8'h00, 1'b1, "R1 byte after foreign address ignored");
        m_stop();
        chk("R1 no write on foreign address", 64'(shift), 64'h55_44_33_22_11);

        // R10 / R6 / R11 write across status and wrap
        wr_begin(8'h05);
        m_send(8'h80, 1'b0, "R3 cmd ack");
        m_send(8'hFF, 1'b0, "R6 status byte still acked");
        m_send(8'hAA, 1'b0, "R11 wrapped write ack");
        m_stop();
        chk("R10 cmd_o", 64'(cmd), 64'h80);
        chk("R10 chip_rst_o", 64'(chip_rst), 64'h1);
        chk("R11 wrap to reg0 / R6 status ignored", 64'(shift), 64'h55_44_33_22_AA);

        // R4 / R7 multi-byte read with wrap
        set_ptr(8'h04);
        rd_begin();
        m_recv(8'h55, 1'b0, "R4 read reg4");
        m_recv(8'h80, 1'b0, "R4 read cmd");
        m_recv(8'h01, 1'b0, "R7 status lock80=1 lock40=0 cnt=0");
        m_recv(8'hAA, 1'b1, "R11 read wraps to reg0");
        m_stop();

        // R5 read does not load pointer
        set_ptr(8'h02);
        rd_begin(); m_recv(8'h33, 1'b1, "R5 first single read"); m_stop();
        rd_begin(); m_recv(8'h33, 1'b1, "R5 repeated single read"); m_stop();

        // R11 out of range pointer
        set_ptr(8'h09);
        rd_begin(); m_recv(8'h00, 1'b1, "R11 pointer above 6 reads zero"); m_stop();
        wr_begin(8'h09);
        m_send(8'h77, 1'b0, "R11 out-of-range data ack");
        m_stop();
        chk("R11 out-of-range write discarded (shift)", 64'(shift), 64'h55_44_33_22_AA);
        chk("R11 out-of-range write discarded (cmd)", 64'(cmd), 64'h80);

        // R8 single upset correction
        inject(3'd1, 2'd1, 3'd3);
        chk("R8 voted output unchanged", 64'(shift), 64'h55_44_33_22_AA);
        set_ptr(8'h06);
        rd_begin(); m_recv(8'h05, 1'b1, "R8 counter one after register upset"); m_stop();
        inject(3'd7, 2'd0, 3'd0);
        rd_begin(); m_recv(8'h09, 1'b1, "R8 pointer upset corrected, counter two"); m_stop();
        inject(3'd6, 2'd2, 3'd5);
        rd_begin(); m_recv(8'h0D, 1'b1, "R8 counter copy upset, counter three"); m_stop();

        // R9 saturation
        for (int k = 0; k < 70; k++) inject(3'd0, 2'd0, 3'd0);
        chk("R8 output stable after many upsets", 64'(shift), 64'h55_44_33_22_AA);
        rd_begin(); m_recv(8'hFD, 1'b1, "R9 counter saturated at 63"); m_stop();

        // R10 counter clear
        wr_begin(8'h05); m_send(8'h08, 1'b0, "R3 cmd ack"); m_stop();
        chk("R10 cmd_o clear bit", 64'(cmd), 64'h08);
        chk("R10 chip_rst_o low", 64'(chip_rst), 64'h0);
        set_ptr(8'h06);
        rd_begin(); m_recv(8'h01, 1'b1, "R10 counter held at zero"); m_stop();
        wr_begin(8'h05); m_send(8'h00, 1'b0, "R3 cmd ack"); m_stop();
        inject(3'd2, 2'd2, 3'd7);
        lock80 = 1'b0; lock40 = 1'b1;
        wq(2);
        set_ptr(8'h06);
        rd_begin(); m_recv(8'h06, 1'b1, "R7 status lock40=1 lock80=0 cnt=1"); m_stop();

        wq(4);
        chk("R12 SDA released when idle", 64'(sda_oe), 64'h0);
        wq(10);
        chk("scoreboard drained", 64'(exp_q.size()), 64'h0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule